// File: doc/BRIEF.md
# SERDES Word-Clock and Transfer-Strobe Generator

This block runs entirely on the fast bit clock of a serialiser or deserialiser lane. It counts bit-clock cycles and derives three outputs from that count:

- a divided word clock for the parallel side;
- a transfer strobe that is high for one bit-clock cycle per word, marking when a word may move between the serial shift register and the parallel register;
- a lock flag. This is an incoming PLL-lock indication re-timed into the word-clock domain.

The word clock rises on the bit-clock edge right after the strobe. A parallel register clocked by the word clock therefore sees the freshly transferred word with a full word period of margin.

For a single-data-rate lane, the divide ratio equals the deserialiser word width. For a double-data-rate lane, the doubler option is set. Each fast cycle then carries two bits (the second bit is taken on an inverted copy of the fast clock outside this block), so a word spans half as many fast cycles.

Top module: `serdes_div_strobe`

## Requirements
- R1: While reset is sampled high, and on the edge that samples it, `div_clk`, `xfer_stb` and `lock_out` are all driven 0.
- R2: With `DOUBLER`=0 and `DIVIDE` from 2 to 8, `div_clk` repeats every `DIVIDE` fast cycles. It is high for the first ceil(`DIVIDE`/2) cycles of each period and low for the rest.
- R3: `xfer_stb` is high for exactly one fast cycle in every word period, and consecutive strobes are one word period apart.
- R4: `xfer_stb` is high only in the last fast cycle of a period, while `div_clk` is low. `div_clk` rises on the very next fast edge.
- R5: With `DOUBLER`=1 (legal for `DIVIDE` of 4, 6 or 8), the word period is `DIVIDE`/2 fast cycles. The high-time rule of R2 and the strobe rules of R3 and R4 apply to that shorter period.
- R6: `lock_in` is sampled only on fast edges where `div_clk` rises, through two stages. A change on `lock_in` appears on `lock_out` at the second `div_clk` rise after the change, and `lock_out` changes on no other edge.
- R7: After reset is released, the first fast edge that samples reset low starts a new period: `div_clk` goes high and `xfer_stb` stays low on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Lock indication to be re-timed |
| div_clk | output | 1 | Divided word clock, registered |
| xfer_stb | output | 1 | One-cycle word transfer strobe, registered |
| lock_out | output | 1 | Lock indication re-timed to word-clock rises |

## Verification
The strobe's successor edge is also the edge on which the lock synchroniser advances. A `div_clk` rise, the end of a strobe and a possible `lock_out` change can therefore all land on one fast edge. The bench provokes this by toggling `lock_in` at phases unrelated to the word period, in every divide ratio and in doubler mode. It then counts word-clock rises between the `lock_in` change and the `lock_out` change, and demands exactly two. In the same cycles it checks that the strobe sits directly before each of those rises.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;

  // fast cycles per word period
  function automatic int period_of(input int div, input bit dbl);
    return dbl ? (div / 2) : div;
  endfunction

  // fast cycles per period with the word clock high
  function automatic int high_of(input int per);
    return (per + 1) / 2;
  endfunction

  function automatic bit cfg_ok(input int div, input bit dbl);
    return (div >= 2) && (div <= 8) && (!dbl || ((div % 2) == 0 && div >= 4));
  endfunction

endpackage

// File: rtl/sdc_phase_ctr.sv
`timescale 1ns/1ps
module sdc_phase_ctr #(
  parameter int PER = 4,
  parameter int W   = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] ph_next,
  output logic         wrap_next
);
  localparam logic [W-1:0] LAST = W'(PER - 1);

  logic [W-1:0] ph;

  always_comb begin
    wrap_next = (ph == LAST);
    ph_next   = wrap_next ? '0 : ph + W'(1);
  end

  // reset parks on the last phase so the first live edge opens a period
  always_ff @(posedge clk) begin
    if (rst) ph <= LAST;
    else     ph <= ph_next;
  end
endmodule

// File: rtl/sdc_out_gen.sv
`timescale 1ns/1ps
module sdc_out_gen #(
  parameter int PER = 4,
  parameter int HI  = 2,
  parameter int W   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ph_next,
  output logic         div_clk,
  output logic         xfer_stb
);
  localparam logic [W-1:0] LAST = W'(PER - 1);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_clk  <= 1'b0;
      xfer_stb <= 1'b0;
    end else begin
      div_clk  <= (ph_next < HI_V);
      xfer_stb <= (ph_next == LAST);
    end
  end
endmodule

// File: rtl/sdc_lock_sync.sv
`timescale 1ns/1ps
module sdc_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)     sh <= '0;
    else if (en) sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/serdes_div_strobe.sv
`timescale 1ns/1ps
module serdes_div_strobe #(
  parameter int DIVIDE      = 4,
  parameter bit DOUBLER     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_fast,
  input  logic rst,
  input  logic lock_in,
  output logic div_clk,
  output logic xfer_stb,
  output logic lock_out
);
  localparam int PER = sdc_pkg::period_of(DIVIDE, DOUBLER);
  localparam int HI  = sdc_pkg::high_of(PER);
  localparam int W   = (PER > 2) ? $clog2(PER) : 1;

  if (!sdc_pkg::cfg_ok(DIVIDE, DOUBLER)) begin : g_bad_cfg
    $error("serdes_div_strobe: unsupported DIVIDE/DOUBLER combination");
  end

  logic [W-1:0] ph_next;
  logic         wrap_next;

  sdc_phase_ctr #(.PER(PER), .W(W)) u_ctr (
    .clk       (clk_fast),
    .rst       (rst),
    .ph_next   (ph_next),
    .wrap_next (wrap_next)
  );

  sdc_out_gen #(.PER(PER), .HI(HI), .W(W)) u_out (
    .clk      (clk_fast),
    .rst      (rst),
    .ph_next  (ph_next),
    .div_clk  (div_clk),
    .xfer_stb (xfer_stb)
  );

  // advances only on the edge where div_clk is registered high from low
  sdc_lock_sync #(.STAGES(SYNC_STAGES)) u_lock (
    .clk (clk_fast),
    .rst (rst),
    .en  (wrap_next),
    .d   (lock_in),
    .q   (lock_out)
  );
endmodule

// File: rtl/sdc_checker.sv
`timescale 1ns/1ps
module sdc_checker #(
  parameter int DIVIDE  = 4,
  parameter bit DOUBLER = 1'b0
) (
  input logic clk_fast,
  input logic rst,
  input logic div_clk,
  input logic xfer_stb,
  input logic lock_out
);
  localparam int PER = sdc_pkg::period_of(DIVIDE, DOUBLER);

  logic       dprev;
  logic       seen;
  logic [3:0] gap;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      dprev <= 1'b0;
      seen  <= 1'b0;
      gap   <= '0;
    end else begin
      dprev <= div_clk;
      if (div_clk && !dprev) begin
        gap  <= 4'd1;
        seen <= 1'b1;
      end else if (gap != 4'hF) begin
        gap <= gap + 4'd1;
      end
    end
  end

  // R2
  period_len_chk: assert property (@(posedge clk_fast) disable iff (rst)
    (seen && $rose(div_clk)) |-> (gap == 4'(PER)));

  // R3
  strobe_single_chk: assert property (@(posedge clk_fast) disable iff (rst)
    xfer_stb |=> !xfer_stb);

  // R4
  strobe_lead_chk: assert property (@(posedge clk_fast) disable iff (rst)
    xfer_stb |=> $rose(div_clk));

  // R4
  strobe_low_chk: assert property (@(posedge clk_fast) disable iff (rst)
    xfer_stb |-> !div_clk);

  // R6
  lock_edge_chk: assert property (@(posedge clk_fast) disable iff (rst)
    !$stable(lock_out) |-> $rose(div_clk));
endmodule

bind serdes_div_strobe sdc_checker #(.DIVIDE(DIVIDE), .DOUBLER(DOUBLER)) u_sdc_chk (
  .clk_fast (clk_fast),
  .rst      (rst),
  .div_clk  (div_clk),
  .xfer_stb (xfer_stb),
  .lock_out (lock_out)
);

// File: tb/test_serdes_div_strobe.sv
`timescale 1ns/1ps
module sdc_tb_lane #(
  parameter int DIV = 4,
  parameter bit DBL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output int   n_chk,
  output int   n_fail,
  output logic done
);
  localparam int    PER  = DBL ? DIV / 2 : DIV;
  localparam int    HI   = (PER + 1) / 2;
  localparam string PTAG = DBL ? "R5" : "R2";

  logic lock_in;
  logic div_clk, xfer_stb, lock_out;

  serdes_div_strobe #(.DIVIDE(DIV), .DOUBLER(DBL)) i_serdes_div_strobe (
    .clk_fast (clk),
    .rst      (rst),
    .lock_in  (lock_in),
    .div_clk  (div_clk),
    .xfer_stb (xfer_stb),
    .lock_out (lock_out)
  );

  // behavioural reference: phase number and two lock samples per word
  int mp;
  bit live, started, ms1, ms2;
  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      live = 1'b0; mp = PER - 1; ms1 = 1'b0; ms2 = 1'b0;
    end else begin
      live = 1'b1;
      mp = (mp + 1) % PER;
      if (mp == 0) begin ms2 = ms1; ms1 = lock_in; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s DIV=%0d DBL=%0d t=%0t actual=%0d expected=%0d",
               tag, DIV, DBL, $time, act, exp);
    end
  endtask

  bit pd, ps, pl_in, pl_out, gseen, armed;
  int gap, rises, rel_cnt;
  always @(negedge clk) begin
    if (started) begin
      if (!live) begin
        // R1 all outputs cleared under reset
        check({div_clk, xfer_stb, lock_out} == 3'b000, "R1",
              int'({div_clk, xfer_stb, lock_out}), 0);
      end else begin
        check(div_clk == (mp < HI), PTAG, int'(div_clk), int'(mp < HI));
        check(xfer_stb == (mp == PER - 1), "R3", int'(xfer_stb), int'(mp == PER - 1));
        check(lock_out == ms2, "R6", int'(lock_out), int'(ms2));
      end
      // R3 / R5 strobe spacing
      if (!live) begin gseen = 0; gap = 0; end
      else begin
        gap++;
        if (xfer_stb) begin
          if (gseen) check(gap == PER, DBL ? "R5" : "R3", gap, PER);
          gseen = 1; gap = 0;
        end
      end
      // R4 word clock rises right after the strobe
      if (live && ps) check(div_clk && !pd, "R4", int'({pd, div_clk}), 1);
      // R7 first live edge opens a period
      if (rst) rel_cnt = 0; else rel_cnt++;
      if (rel_cnt == 2) check(div_clk && !xfer_stb, "R7", int'({div_clk, xfer_stb}), 2);
      // R6 lock latency in word-clock rises
      if (rst) armed = 0;
      else begin
        if (armed && div_clk && !pd) rises++;
        if (armed && lock_out != pl_out) begin
          check(rises == 2, "R6", rises, 2);
          armed = 0;
        end
        if (lock_in != pl_in) begin armed = 1; rises = 0; end
      end
      pd = div_clk; ps = xfer_stb; pl_in = lock_in; pl_out = lock_out;
    end
  end

  initial begin
    done = 1'b0;
    lock_in = 1'b0;
    wait (rst === 1'b1);
    wait (rst === 1'b0);
    repeat (20) @(posedge clk);
    #1 lock_in = 1'b1;
    repeat (40) @(posedge clk);
    #1 lock_in = 1'b0;
    repeat (37) @(posedge clk);
    #1 lock_in = 1'b1;
    wait (rst === 1'b1);
    wait (rst === 1'b0);
    repeat (30) @(posedge clk);
    #1 lock_in = 1'b0;
    repeat (40) @(posedge clk);
    done = 1'b1;
  end
endmodule

module test_serdes_div_strobe;
  localparam int NU = 10;
  localparam int DIVS [NU] = '{2, 3, 4, 5, 6, 7, 8, 4, 6, 8};
  localparam bit DBLS [NU] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  wire [31:0]   unit_chk  [NU];
  wire [31:0]   unit_fail [NU];
  wire [NU-1:0] done_v;

  for (genvar k = 0; k < NU; k++) begin : g_lane
    sdc_tb_lane #(.DIV(DIVS[k]), .DBL(DBLS[k])) u_lane (
      .clk    (clk),
      .rst    (rst),
      .n_chk  (unit_chk[k]),
      .n_fail (unit_fail[k]),
      .done   (done_v[k])
    );
  end

  initial begin
    int tc, tf;
    rst = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (150) @(posedge clk);
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      if (&done_v) break;
      @(posedge clk);
    end
    repeat (2) @(negedge clk);
    tc = 0; tf = 0;
    for (int k = 0; k < NU; k++) begin
      tc += int'(unit_chk[k]);
      tf += int'(unit_fail[k]);
    end
    if (!(&done_v)) begin
      tc++; tf++;
      $display("FAIL watchdog actual=%0h expected=%0h", done_v, {NU{1'b1}});
    end
    $display("TB_RESULT checks=%0d failures=%0d", tc, tf);
    $finish;
  end
endmodule